// File: doc/BRIEF.md
# Three-Queue Shared-Storage FIFO

This block holds three independent first-in, first-out queues in one pool of 18-bit storage. The pool is split into sixteen blocks of 256 words. A per-block owner field gives each block to one of the queues or leaves it unused. A queue therefore holds 256 words for every block it owns. Its words are stored in those blocks in ascending block-number order, and it wraps back to its first block.

Writes happen in the write-clock domain. There is one enable per queue, so a single word can be copied into any mix of the three queues on one edge. Reads happen in an independent read-clock domain. A 2-bit select picks the queue and a single enable requests a word. The read and write counts of each queue cross between the two domains as Gray code through two-stage synchronizers. Each domain takes its own copy of the owner fields while its reset is held.

Top module: `multi_queue_fifo`

## Requirements
- R1: After both resets are released, `rd_empty` is 3'b111, `rd_valid` is 0, and `wr_full` is high exactly for the queues that own no block.
- R2: The owner of block b is the 2-bit field `blk_owner[2b+1:2b]`. The values 0, 1 and 2 name a queue and 3 leaves the block unused. Each queue's capacity is 256 times the number of blocks it owns.
- R3: On a rising `wr_clk` edge with `wr_en[q]` high and `wr_full[q]` low, `wr_data` is appended to queue q, and words leave each queue in the order they were accepted.
- R4: When several bits of `wr_en` are high on one edge, the same `wr_data` word is appended to every enabled queue that is not full.
- R5: On a rising `rd_clk` edge with `rd_en` high, `rd_sel` = q (0 to 2) and queue q not empty, the oldest word of q appears on `rd_data` with `rd_valid` high after that edge. Otherwise `rd_valid` is low after that edge. `rd_sel` = 3 reads nothing and leaves all queues unchanged.
- R6: `wr_full[q]` is high when queue q holds as many words as its capacity. A write to a full queue is dropped.
- R7: `rd_empty[q]` is high when queue q holds no words. A read of an empty queue is dropped and produces no `rd_valid`.
- R8: A queue that owns no block is always full and accepts no word.
- R9: The order of words in a queue is kept across non-adjacent owned blocks and across the wrap from the last owned block to the first.
- R10: Each queue's counts cross the clock domains as Gray code that changes by at most one bit per edge. Space freed by reads clears `wr_full` within a few write-clock cycles.
- R11: Changes to `blk_owner` while the resets are released do not change any queue's capacity or block mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| blk_owner | input | 32 | Owner field per block (2 bits each), taken during reset |
| wr_en | input | 3 | Per-queue write enable |
| wr_data | input | 18 | Word to write |
| wr_full | output | 3 | Per-queue full flag, write domain |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Queue to read (3 = none) |
| rd_data | output | 18 | Word read, registered |
| rd_valid | output | 1 | `rd_data` carries a word read on the last edge |
| rd_empty | output | 3 | Per-queue empty flag, read domain |

## Verification
The assertions assume that both resets are held together for several cycles of each clock. They also assume that `blk_owner` is stable during reset and never gives one block to two queues, which the 2-bit field format ensures. The flags lag the far domain by the synchronizer delay. The stimulus therefore waits for the counts to settle between bursts of writes and bursts of reads, so that the bench can predict every flag and every read exactly from its own word count per queue. The owner fields change only after the resets are released, which exercises the freeze without breaking the reset-time assumption.

// File: rtl/mqf_pkg.sv
// Shared constants and Gray-code helpers for the three-queue FIFO.
// Assumes counts of at most 32 bits; callers size the results down.
package mqf_pkg;
    localparam int NUM_QUEUES = 3;
    localparam logic [1:0] OWNER_NONE = 2'd3;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary by prefix XOR.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction
endpackage

// File: rtl/mqf_sync.sv
// Two-stage synchronizer for a Gray-coded count.
// Assumes the input changes by at most one bit per source-clock edge.
module mqf_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign count, then retime it once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mqf_alloc.sv
// Block-ownership decoder: while reset is held, it turns the per-block owner
// fields into a block count per queue and an ordered list of the physical
// blocks each queue owns. It holds both when reset is released.
// Assumes blk_owner is stable during reset.
module mqf_alloc
    import mqf_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int BLK_IW  = $clog2(NUM_BLK),
    parameter int CNTW    = $clog2(NUM_BLK + 1)
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [2*NUM_BLK-1:0]                          blk_owner,
    output logic [NUM_QUEUES-1:0][CNTW-1:0]               blk_cnt,
    output logic [NUM_QUEUES-1:0][NUM_BLK-1:0][BLK_IW-1:0] blk_map
);
    logic [NUM_QUEUES-1:0][CNTW-1:0]                cnt_n;
    logic [NUM_QUEUES-1:0][NUM_BLK-1:0][BLK_IW-1:0] map_n;

    // List each queue's blocks in ascending physical order.
    always_comb begin
        cnt_n = '0;
        map_n = '0;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                if (blk_owner[2*b +: 2] == 2'(q)) begin
                    map_n[q][cnt_n[q][BLK_IW-1:0]] = BLK_IW'(b);
                    cnt_n[q] = CNTW'(cnt_n[q] + 1'b1);
                end
            end
        end
    end

    // Take the decoded allocation only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= cnt_n;
            blk_map <= map_n;
        end
    end

    p_alloc_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(blk_cnt) && $stable(blk_map)));
endmodule

// File: rtl/mqf_bank.sv
// One storage block: one synchronous write port and one asynchronous read port.
// Assumes the block has only one owner, so there is at most one writer per edge.
module mqf_bank #(
    parameter int DATA_W = 18,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [2**AW];

    // Store the word on an enabled write edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/multi_queue_fifo.sv
// Three FIFO queues sharing banked storage. Each queue walks the blocks it
// owns, in ascending order. Writes may copy one word into several queues.
// Reads take the selected queue in a separate clock domain.
// Assumes both resets are held together and the owner fields are stable then.
module multi_queue_fifo
    import mqf_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int BLK_AW  = 8,
    parameter int NUM_BLK = 16
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic [2*NUM_BLK-1:0] blk_owner,
    input  logic [2:0]           wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [2:0]           wr_full,
    input  logic                 rd_en,
    input  logic [1:0]           rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [2:0]           rd_empty
);
    localparam int NQ     = NUM_QUEUES;
    localparam int BLK_IW = $clog2(NUM_BLK);
    localparam int CNTW   = $clog2(NUM_BLK + 1);
    localparam int PTRW   = CNTW + BLK_AW;

    // Allocation copies, one per clock domain.
    logic [NQ-1:0][CNTW-1:0]                blk_cnt_w, blk_cnt_r;
    logic [NQ-1:0][NUM_BLK-1:0][BLK_IW-1:0] blk_map_w, blk_map_r;

    mqf_alloc #(.NUM_BLK(NUM_BLK), .BLK_IW(BLK_IW), .CNTW(CNTW)) u_alloc_w (
        .clk(wr_clk), .rst_n(wr_rst_n), .blk_owner(blk_owner),
        .blk_cnt(blk_cnt_w), .blk_map(blk_map_w)
    );
    mqf_alloc #(.NUM_BLK(NUM_BLK), .BLK_IW(BLK_IW), .CNTW(CNTW)) u_alloc_r (
        .clk(rd_clk), .rst_n(rd_rst_n), .blk_owner(blk_owner),
        .blk_cnt(blk_cnt_r), .blk_map(blk_map_r)
    );

    // Per-queue write state.
    logic [PTRW-1:0]   wcnt [NQ];
    logic [PTRW-1:0]   wgray [NQ];
    logic [PTRW-1:0]   rgray_w [NQ];
    logic [BLK_IW-1:0] wblk [NQ];
    logic [BLK_AW-1:0] woff [NQ];
    logic [BLK_IW-1:0] wphys [NQ];
    logic [NQ-1:0]     wacc;

    // Per-queue read state.
    logic [PTRW-1:0]   rcnt [NQ];
    logic [PTRW-1:0]   rgray [NQ];
    logic [PTRW-1:0]   wgray_r [NQ];
    logic [BLK_IW-1:0] rblk [NQ];
    logic [BLK_AW-1:0] roff [NQ];
    logic [NQ-1:0]     racc;

    genvar gq;
    for (gq = 0; gq < NQ; gq++) begin : g_wq
        logic [PTRW-1:0] rcnt_seen, occ, cap;

        mqf_sync #(.W(PTRW)) u_sync_r2w (
            .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray[gq]), .q(rgray_w[gq])
        );

        assign rcnt_seen   = PTRW'(from_gray(32'(rgray_w[gq])));
        assign cap         = PTRW'(blk_cnt_w[gq]) << BLK_AW;
        assign occ         = wcnt[gq] - rcnt_seen;
        assign wr_full[gq] = (occ == cap);
        assign wacc[gq]    = wr_en[gq] & ~wr_full[gq];
        assign wphys[gq]   = blk_map_w[gq][wblk[gq]];

        // Advance the write count and the in-queue position on an accepted word.
        always_ff @(posedge wr_clk) begin
            if (!wr_rst_n) begin
                wcnt[gq]  <= '0;
                wgray[gq] <= '0;
                wblk[gq]  <= '0;
                woff[gq]  <= '0;
            end else if (wacc[gq]) begin
                wcnt[gq]  <= wcnt[gq] + 1'b1;
                wgray[gq] <= PTRW'(to_gray(32'(wcnt[gq] + 1'b1)));
                woff[gq]  <= woff[gq] + 1'b1;
                if (woff[gq] == '1) begin
                    wblk[gq] <= (wblk[gq] == BLK_IW'(blk_cnt_w[gq] - 1'b1))
                                ? '0 : wblk[gq] + 1'b1;
                end
            end
        end

        p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
            occ <= cap);
        p_full_hold_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
            (wr_en[gq] && wr_full[gq]) |=> $stable(wcnt[gq]));
        p_zero_blk_r8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
            (blk_cnt_w[gq] == '0) |-> wr_full[gq]);
        p_gray_step_w_r10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
            $onehot0(wgray[gq] ^ $past(wgray[gq])));
    end

    // Storage banks; each bank's write comes from the queue that owns it.
    logic [NUM_BLK-1:0] bank_we;
    logic [BLK_AW-1:0]  bank_wa [NUM_BLK];
    logic [DATA_W-1:0]  bank_rd [NUM_BLK];
    logic [BLK_AW-1:0]  rd_off_sel;

    // Route each accepted write to the bank its queue currently points into.
    always_comb begin
        for (int b = 0; b < NUM_BLK; b++) begin
            bank_we[b] = 1'b0;
            bank_wa[b] = '0;
            for (int q = 0; q < NQ; q++) begin
                if (wacc[q] && wphys[q] == BLK_IW'(b)) begin
                    bank_we[b] = 1'b1;
                    bank_wa[b] = woff[q];
                end
            end
        end
    end

    genvar gb;
    for (gb = 0; gb < NUM_BLK; gb++) begin : g_bank
        mqf_bank #(.DATA_W(DATA_W), .AW(BLK_AW)) u_bank (
            .clk(wr_clk), .we(bank_we[gb]), .waddr(bank_wa[gb]), .wdata(wr_data),
            .raddr(rd_off_sel), .rdata(bank_rd[gb])
        );
    end

    for (gq = 0; gq < NQ; gq++) begin : g_rq
        logic [PTRW-1:0] wcnt_seen, cap_r;

        mqf_sync #(.W(PTRW)) u_sync_w2r (
            .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray[gq]), .q(wgray_r[gq])
        );

        assign wcnt_seen    = PTRW'(from_gray(32'(wgray_r[gq])));
        assign cap_r        = PTRW'(blk_cnt_r[gq]) << BLK_AW;
        assign rd_empty[gq] = (rcnt[gq] == wcnt_seen);
        assign racc[gq]     = rd_en && (rd_sel == 2'(gq)) && !rd_empty[gq];

        // Advance the read count and the in-queue position on an accepted read.
        always_ff @(posedge rd_clk) begin
            if (!rd_rst_n) begin
                rcnt[gq]  <= '0;
                rgray[gq] <= '0;
                rblk[gq]  <= '0;
                roff[gq]  <= '0;
            end else if (racc[gq]) begin
                rcnt[gq]  <= rcnt[gq] + 1'b1;
                rgray[gq] <= PTRW'(to_gray(32'(rcnt[gq] + 1'b1)));
                roff[gq]  <= roff[gq] + 1'b1;
                if (roff[gq] == '1) begin
                    rblk[gq] <= (rblk[gq] == BLK_IW'(blk_cnt_r[gq] - 1'b1))
                                ? '0 : rblk[gq] + 1'b1;
                end
            end
        end

        p_no_underrun_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
            (wcnt_seen - rcnt[gq]) <= cap_r);
        p_empty_hold_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
            (rd_en && rd_sel == 2'(gq) && rd_empty[gq]) |=> $stable(rcnt[gq]));
        p_gray_step_r_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
            $onehot0(rgray[gq] ^ $past(rgray[gq])));
    end

    // Selected queue's physical bank and offset; select 3 falls back to queue 0.
    logic [1:0]        sel_i;
    logic [BLK_IW-1:0] rphys;

    assign sel_i      = (rd_sel < 2'(NQ)) ? rd_sel : 2'd0;
    assign rphys      = blk_map_r[sel_i][rblk[sel_i]];
    assign rd_off_sel = roff[sel_i];

    // Register the word of an accepted read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= |racc;
            if (|racc) rd_data <= bank_rd[rphys];
        end
    end

    p_valid_src_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> ($past(rd_en) && $past(rd_sel) != 2'd3));
endmodule

// File: tb/multi_queue_fifo_test.sv
// Scoreboard bench: driver tasks push expected words per queue, and a monitor
// on the read clock pops and compares them as rd_valid words come out.
module multi_queue_fifo_test;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst_n = 0, rd_rst_n = 0;
    logic [31:0] blk_owner;
    logic [2:0]  wr_en = '0;
    logic [17:0] wr_data = '0;
    logic [2:0]  wr_full;
    logic        rd_en = 0;
    logic [1:0]  rd_sel = '0;
    logic [17:0] rd_data;
    logic        rd_valid;
    logic [2:0]  rd_empty;

    multi_queue_fifo uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .blk_owner(blk_owner), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_empty(rd_empty)
    );

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    int    cap [3] = '{256, 512, 0};
    string cur_tag = "R3";
    logic [17:0] sb0 [$], sb1 [$], sb2 [$];

    function automatic int sb_size(int q);
        return (q == 0) ? sb0.size() : (q == 1) ? sb1.size() : sb2.size();
    endfunction
    function automatic void sb_push(int q, logic [17:0] d);
        if (q == 0) sb0.push_back(d); else if (q == 1) sb1.push_back(d); else sb2.push_back(d);
    endfunction
    function automatic logic [17:0] sb_pop(int q);
        return (q == 0) ? sb0.pop_front() : (q == 1) ? sb1.pop_front() : sb2.pop_front();
    endfunction

    task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one write per call; predicts acceptance from the scoreboard fill.
    task automatic wr_word(logic [2:0] en, logic [17:0] d);
        @(posedge wr_clk); #1;
        wr_en = en; wr_data = d;
        for (int q = 0; q < 3; q++)
            if (en[q] && sb_size(q) < cap[q]) sb_push(q, d);
    endtask
    task automatic wr_stop();
        @(posedge wr_clk); #1; wr_en = '0;
    endtask
    task automatic rd_word(logic [1:0] q);
        @(posedge rd_clk); #1; rd_en = 1; rd_sel = q;
    endtask
    task automatic rd_stop();
        @(posedge rd_clk); #1; rd_en = 0;
    endtask
    task automatic settle();
        repeat (10) @(posedge rd_clk);
    endtask

    // Monitor: compare the read issued on the last edge, then note the next one.
    bit          pend_on = 0, pend_valid = 0;
    logic [17:0] pend_data = '0;
    string       pend_tag = "R5";
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (pend_on) begin
                n_vec++;
                if (pend_valid && (rd_valid !== 1'b1 || rd_data !== pend_data)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h",
                             pend_tag, rd_valid, rd_data, pend_data);
                end else if (!pend_valid && rd_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL %s: valid=%b expected valid=0", pend_tag, rd_valid);
                end
            end
            pend_on    = rd_en;
            pend_tag   = cur_tag;
            pend_valid = rd_en && rd_sel != 2'd3 && sb_size(int'(rd_sel)) > 0;
            if (pend_valid) pend_data = sb_pop(int'(rd_sel));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(WR_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // Allocation: block 5 -> q0, blocks 0 and 9 -> q1, q2 none, rest unused (3).
        blk_owner = '1;
        blk_owner[2*5 +: 2] = 2'd0;
        blk_owner[2*0 +: 2] = 2'd1;
        blk_owner[2*9 +: 2] = 2'd1;
        repeat (5) @(posedge rd_clk);
        @(posedge wr_clk); #1 wr_rst_n = 1;
        @(posedge rd_clk); #1 rd_rst_n = 1;
        settle();

        // R1 / R8: reset state, zero-block queue full.
        @(negedge rd_clk);
        chk("R1 rd_empty", 18'(rd_empty), 18'(3'b111));
        chk("R1 rd_valid", 18'(rd_valid), 18'd0);
        @(negedge wr_clk);
        chk("R1 R8 wr_full", 18'(wr_full), 18'(3'b100));

        // R4 / R3: broadcast into all three; q2 drops the words.
        cur_tag = "R4";
        for (int i = 0; i < 20; i++) wr_word(3'b111, 18'h00100 + 18'(i));
        wr_stop();
        settle();
        @(negedge rd_clk);
        chk("R4 rd_empty", 18'(rd_empty), 18'(3'b100));
        cur_tag = "R3";
        for (int i = 0; i < 10; i++) rd_word(2'd1);
        for (int i = 0; i < 20; i++) rd_word(2'd0);
        for (int i = 0; i < 10; i++) rd_word(2'd1);
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) rd_word(2'd0);
        rd_stop();
        settle();

        // R11: owner fields change after reset; q0 must keep its 256 words.
        blk_owner = '0;
        cur_tag = "R6";
        for (int i = 0; i < 300; i++) wr_word(3'b001, 18'h20000 + 18'(i));
        wr_stop();
        @(negedge wr_clk);
        chk("R6 R11 wr_full", 18'(wr_full), 18'(3'b101));
        settle();
        cur_tag = "R11";
        for (int i = 0; i < 260; i++) rd_word(2'd0);
        rd_stop();
        settle();
        @(negedge wr_clk);
        chk("R10 wr_full after drain", 18'(wr_full), 18'(3'b100));

        // R9: q1 fills across blocks 0 and 9, starting mid-block, and wraps.
        cur_tag = "R9";
        for (int i = 0; i < 600; i++) wr_word(3'b010, 18'h30000 + 18'(i));
        wr_stop();
        @(negedge wr_clk);
        chk("R9 R2 wr_full", 18'(wr_full), 18'(3'b110));
        settle();
        for (int i = 0; i < 520; i++) rd_word(2'd1);
        rd_stop();
        settle();

        // R5: select 3 reads nothing and leaves q0 intact.
        for (int i = 0; i < 3; i++) wr_word(3'b001, 18'h0abc0 + 18'(i));
        wr_stop();
        settle();
        cur_tag = "R5";
        for (int i = 0; i < 5; i++) rd_word(2'd3);
        rd_stop();
        @(negedge rd_clk);
        chk("R5 rd_empty after sel 3", 18'(rd_empty), 18'(3'b110));
        for (int i = 0; i < 4; i++) rd_word(2'd0);
        rd_stop();
        settle();
        @(negedge rd_clk);
        chk("R7 rd_empty final", 18'(rd_empty), 18'(3'b111));
        finish_run();
    end
endmodule